// File: doc/BRIEF.md
# Timer interrupt enable and status register

This block keeps the interrupt controls for a bank of five countdown timer channels. A single 10-bit register packs one enable bit per channel in its low half and one sticky status flag per channel in its high half. Each channel also owns a level-sensitive interrupt line. The counters are outside this block. They report an expiry as a one-cycle pulse on `expire_i`. The pulse always latches the channel's status flag. It raises the channel's interrupt line only when the enable bit is already set in that cycle.

Software reaches the register through a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr_en` is high, and a read is a combinational view of the stored state. The port carries no stream traffic, so it has no valid/ready handshake and never applies back-pressure: every write is accepted in the cycle it is presented.

Enable bits are written directly. Status bits are write-one-to-clear, and clearing a channel's status drops its interrupt line. The line is sampled at expiry, not formed continuously from status AND enable. Setting an enable after an expiry therefore raises nothing, and clearing an enable leaves a raised line high.

Top module: `tint_ctrl_top`

## Requirements
- R1: After reset, `reg_rd_data` reads 0 and every `irq_o` bit is 0.
- R2: A write loads the enable of channel n from `reg_wr_data` bit n (bits 4:0), and the new value is visible on `reg_rd_data` bits 4:0 from the next cycle.
- R3: A write with `reg_wr_data` bit 5+n set clears the status flag of channel n (read at bit 5+n). A write with that bit 0 leaves the flag unchanged.
- R4: An `expire_i[n]` pulse sets status bit 5+n in the next cycle, whether or not enable n is set.
- R5: `irq_o[n]` rises in the cycle after an `expire_i[n]` pulse only if enable n was set in the pulse cycle. Setting enable n later, while status n is still set, does not raise the line.
- R6: `irq_o[n]` falls in the cycle after a write that clears a set status flag n. Clearing enable n alone does not lower a raised line.
- R7: When an expiry and a clearing write hit the same channel in the same cycle, the status flag stays set and the line is not lowered.
- R8: `reg_rd_data` bits 31:10 always read 0, and writes to those bits have no effect on any readable bit or line.
- R9: Channels are independent: an expiry or clear on one channel changes no other channel's status or line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| expire_i | input | 5 | One-cycle expiry pulse per channel from the counters |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Write data: bits 4:0 enables, bits 9:5 clear-on-one status |
| reg_rd_data | output | 32 | Read data: bits 4:0 enables, bits 9:5 status, rest zero |
| irq_o | output | 5 | Level interrupt line per channel |

## Verification
Any corruption of an enable, a status flag or a line shows on the ports one cycle after the edge that caused it. Every stored bit is visible either in the read word or on `irq_o`. The bench compares the full read word and all five lines after every single cycle of stimulus, so a wrong bit is caught in the cycle it appears and not at some later drain point. The sampled-at-expiry behaviour cannot be seen at one instant. It is exposed by sequences such as enabling after an expiry, disabling after a raise, or an expiry coinciding with a clear, and each of these is followed by a comparison one cycle later.

// File: rtl/tint_pkg.sv
package tint_pkg;
  parameter int unsigned TINT_NUM_CH = 5;
  parameter int unsigned TINT_DATA_W = 32;

  // Readable image of the register: enables low, status above them.
  function automatic logic [TINT_DATA_W-1:0] tint_pack(
    input logic [TINT_NUM_CH-1:0] st,
    input logic [TINT_NUM_CH-1:0] en
  );
    logic [TINT_DATA_W-1:0] img;
    img = '0;
    img[TINT_NUM_CH-1:0] = en;
    img[2*TINT_NUM_CH-1:TINT_NUM_CH] = st;
    return img;
  endfunction
endpackage

// File: rtl/tint_enable_bank.sv
module tint_enable_bank #(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_bits,
  output logic [NUM_CH-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_bits;
  end

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == $past(wr_bits));

  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/tint_status_cell.sv
module tint_status_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  output logic st_q,
  output logic clr_done
);
  logic st_d;

  // A clear only counts when it removes a set flag and no expiry overrides it.
  assign clr_done = clr_req & st_q & ~expire;

  always_comb begin
    st_d = st_q;
    if (expire)       st_d = 1'b1;
    else if (clr_req) st_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  // R4
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> st_q);

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !st_q);

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !expire) |=> $stable(st_q));
endmodule

// File: rtl/tint_irq_line.sv
module tint_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic en,
  input  logic clr_done,
  input  logic st_q,
  output logic line_q
);
  logic line_d;

  always_comb begin
    line_d = line_q;
    if (expire && en) line_d = 1'b1;
    else if (clr_done) line_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  // R5
  raise_only_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q && !(expire && en)) |=> !line_q);

  // R5
  raise_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && en) |=> line_q);

  // R6
  lower_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !line_q);

  // R6
  line_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> st_q);
endmodule

// File: rtl/tint_ctrl_top.sv
module tint_ctrl_top
  import tint_pkg::*;
#(
  parameter int unsigned NUM_CH = TINT_NUM_CH,
  parameter int unsigned DATA_W = TINT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned ST_LSB = NUM_CH;
  localparam int unsigned ST_MSB = 2 * NUM_CH - 1;
  localparam int unsigned USED_W = 2 * NUM_CH;

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] st_q;
  logic [NUM_CH-1:0] clr_req;
  logic [NUM_CH-1:0] clr_done;
  logic              unused_hi;

  assign unused_hi = ^reg_wr_data[DATA_W-1:USED_W];
  assign clr_req   = reg_wr_en ? reg_wr_data[ST_MSB:ST_LSB] : '0;

  tint_enable_bank #(.NUM_CH(NUM_CH)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_bits (reg_wr_data[NUM_CH-1:0]),
    .en_q    (en_q)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    tint_status_cell u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire_i[ch]),
      .clr_req  (clr_req[ch]),
      .st_q     (st_q[ch]),
      .clr_done (clr_done[ch])
    );

    tint_irq_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire_i[ch]),
      .en       (en_q[ch]),
      .clr_done (clr_done[ch]),
      .st_q     (st_q[ch]),
      .line_q   (irq_o[ch])
    );

    // R7
    expiry_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i[ch] && clr_req[ch]) |=> (st_q[ch] && (irq_o[ch] || !$past(irq_o[ch]))));
  end

  always_comb begin
    reg_rd_data = '0;
    reg_rd_data[NUM_CH-1:0]     = en_q;
    reg_rd_data[ST_MSB:ST_LSB]  = st_q;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (reg_rd_data == '0 && irq_o == '0));
endmodule

// File: tb/tb_tint_ctrl_top.sv
module tb_tint_ctrl_top;
  localparam int N = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] expire_i = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [N-1:0] irq_o;

  always #4 clk = ~clk;  // 125 MHz

  tint_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .expire_i(expire_i),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] rd;
    logic [N-1:0] irq;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Requirement model kept by the driver
  logic [N-1:0] m_en = '0, m_st = '0, m_ln = '0;

  // Monitor: compare one cycle after each driven step
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (reg_rd_data !== e.rd || irq_o !== e.irq) begin
        fails++;
        $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                 e.tag, reg_rd_data, irq_o, e.rd, e.irq);
      end
    end
  end

  task automatic step(input bit wr, input logic [31:0] wd,
                      input logic [N-1:0] ex, input string tag);
    exp_t e;
    @(negedge clk);
    reg_wr_en   = wr;
    reg_wr_data = wd;
    expire_i    = ex;
    for (int n = 0; n < N; n++) begin
      bit clr;
      clr = wr && wd[N+n];
      if (ex[n] && m_en[n])               m_ln[n] = 1'b1;
      else if (clr && m_st[n] && !ex[n])  m_ln[n] = 1'b0;
      if (ex[n])    m_st[n] = 1'b1;
      else if (clr) m_st[n] = 1'b0;
    end
    if (wr) m_en = wd[N-1:0];
    e.rd  = {22'd0, m_st, m_en};
    e.irq = m_ln;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, '0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state while held
    if (reg_rd_data !== 32'h0 || irq_o !== '0) begin
      fails++;
      $display("FAIL R1: rd=%h irq=%b expected rd=0 irq=0", reg_rd_data, irq_o);
    end
    rst_n = 1'b1;
    idle("R1 idle after reset");

    step(1, 32'h0000_0015, '0,      "R2 load enables 10101");
    step(0, 32'h0,         5'h1F,   "R4/R5 expire all, lines follow enables");
    idle("R4 status sticky");
    step(1, 32'h0000_001F, '0,      "R5 late enable does not raise");
    step(1, 32'h0000_003F, '0,      "R3/R6 clear ch0 lowers its line");
    step(1, 32'h0000_0000, '0,      "R6 disable keeps lines high, R3 zero keeps status");
    step(0, 32'h0,         5'h02,   "R4 expire ch1 while disabled");
    step(1, 32'h0000_009F, 5'h04,   "R7 expire and clear ch2 together");
    step(1, 32'hFFFF_FC03, '0,      "R8 upper bits ignored");
    step(1, 32'h0000_03E3, '0,      "R3/R6 clear all status");
    step(0, 32'h0,         5'h09,   "R9 expire ch0 and ch3 only");
    step(1, 32'h0000_0103, 5'h01,   "R9 clear ch3 while ch0 expires");
    step(1, 32'h0000_0023, 5'h01,   "R7 clear ch0 while it expires, enabled");
    step(1, 32'hFFFF_FFFF, '0,      "R8/R3 all-ones write clears status");
    step(0, 32'h0,         5'h10,   "R5 expire ch4 enabled");
    step(1, 32'h0000_000F, '0,      "R6 disable ch4 keeps line");
    step(1, 32'h0000_020F, 5'h10,   "R7 clear ch4 with coincident expiry");
    step(1, 32'h0000_020F, '0,      "R6 clear ch4 lowers line");
    idle("R1 quiet tail");
    idle("R9 quiet tail");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule